// File: doc/BRIEF.md
# Hash State Chain Access Port

This block gives software register access to the working state of a hash engine so that a hash can be paused, saved, resumed and finally read out. The full digest state of up to sixteen 32-bit words is reached through one repeating register address. An internal word pointer selects which state word each access touches. Every chain access that is accepted steps the pointer. The number of words in the cycle depends on the algorithm chosen in the mode register.

The port also holds the 64-bit count of processed message bytes as two 32-bit registers, shows the engine busy flag in a status register, and decodes a start command. Toward the hash core it drives the stored state words, the length, the mode fields and a start pulse. The core can load a complete new state and length in one cycle through a parallel update bus. Read data is registered and appears one cycle after the read strobe. It holds its value until the next read.

Top module: `hash_state_port`

## Requirements
- R1: During and right after reset, the read data, start pulse, mode fields, all state words and the length are zero, and the word pointer is 0.
- R2: A read at offset 0x04 returns the state word at the pointer on reg_rdata_o in the cycle after the read strobe. Each accepted read advances the pointer, starting from word 0.
- R3: A write at offset 0x04 loads the state word at the pointer and advances the pointer. The word appears on state_o[32*i +: 32] for word i.
- R4: Algorithm codes 0, 1 and 4 use 8 chain words, and codes 2 and 3 use 16. After the last word the pointer wraps to 0.
- R5: Algorithm codes 5, 6 and 7 give zero chain words. A chain read returns 0, a chain write changes no state word, and the pointer stays at 0.
- R6: A write to the mode register, or a start command, returns the pointer to 0.
- R7: While busy_i is 1, a chain read returns 0, a chain write changes nothing, and the pointer does not advance.
- R8: Offset 0x60 holds length bits 31:0 and offset 0x64 holds bits 63:32. Both can be read and written, and together they drive len_o.
- R9: A read at offset 0x58 returns busy_i in bit 0, with every other bit 0.
- R10: Offset 0x00 holds the algorithm code in bits 18:16, the HMAC enable in bit 22 and the endianness field in bits 31:26. These fields read back and drive algo_o, hmac_en_o and endian_o. All other bits read as 0.
- R11: A write at offset 0x08 with bit 0 set raises start_o for exactly the next cycle. Reads at 0x08 and at unmapped offsets return 0.
- R12: When core_upd_i is 1, all state words and the length load from core_state_i and core_len_i. This takes precedence over a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 12 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| busy_i | input | 1 | Hash core busy |
| core_upd_i | input | 1 | Core loads full state and length |
| core_state_i | input | 512 | State words from core |
| core_len_i | input | 64 | Length from core |
| state_o | output | 512 | Stored state words to core |
| len_o | output | 64 | Stored length to core |
| algo_o | output | 3 | Algorithm code |
| hmac_en_o | output | 1 | HMAC enable |
| endian_o | output | 6 | Endianness field |
| start_o | output | 1 | One-cycle start pulse |

## Verification
The hardest cases to reach are those where the pointer sits in the middle of the word cycle when something interrupts it. Examples are a mode rewrite or start command after a partial readout, a busy window in the middle of a sequence, and a narrowing of the algorithm from 16 to 8 words. The stimulus runs partial read and write sequences, then injects each of these events at a non-zero pointer. Later reads show which word the pointer resumed at. A core update that lands in the same cycle as a chain write checks that the core load wins while the pointer still advances.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int OFS_MODE   = 'h000;
  localparam int OFS_CHAIN  = 'h004;
  localparam int OFS_OP     = 'h008;
  localparam int OFS_STATUS = 'h058;
  localparam int OFS_LEN_LO = 'h060;
  localparam int OFS_LEN_HI = 'h064;

  localparam int ALGO_LSB   = 16;
  localparam int ALGO_W     = 3;
  localparam int HMAC_BIT   = 22;
  localparam int ENDIAN_LSB = 26;
  localparam int ENDIAN_W   = 6;

  typedef enum logic [ALGO_W-1:0] {
    ALGO_SHA256 = 3'd0,
    ALGO_SHA224 = 3'd1,
    ALGO_SHA384 = 3'd2,
    ALGO_SHA512 = 3'd3,
    ALGO_SM3    = 3'd4
  } algo_e;

  function automatic logic [4:0] chain_words(logic [ALGO_W-1:0] code);
    case (code)
      ALGO_SHA256, ALGO_SHA224, ALGO_SM3: chain_words = 5'd8;
      ALGO_SHA384, ALGO_SHA512:           chain_words = 5'd16;
      default:                            chain_words = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/hsp_mode_reg.sv
module hsp_mode_reg
  import hsp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_we_i,
  input  logic                op_we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [ALGO_W-1:0]   algo_o,
  output logic                hmac_en_o,
  output logic [ENDIAN_W-1:0] endian_o,
  output logic                start_o,
  output logic                ptr_clr_o
);
  logic start_cmd;
  assign start_cmd = op_we_i & wdata_i[0];
  assign ptr_clr_o = mode_we_i | start_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      algo_o    <= '0;
      hmac_en_o <= 1'b0;
      endian_o  <= '0;
      start_o   <= 1'b0;
    end else begin
      start_o <= start_cmd;
      if (mode_we_i) begin
        algo_o    <= wdata_i[ALGO_LSB +: ALGO_W];
        hmac_en_o <= wdata_i[HMAC_BIT];
        endian_o  <= wdata_i[ENDIAN_LSB +: ENDIAN_W];
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_cmd |=> start_o) else $error("start missed"); // R11
  AST_START_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_cmd |=> !start_o) else $error("start spurious"); // R11
endmodule

// File: rtl/hsp_word_ptr.sv
module hsp_word_ptr #(
  parameter int MAX_WORDS = 16,
  localparam int PTR_W = $clog2(MAX_WORDS),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             access_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] nw_i,
  output logic             step_o,
  output logic [PTR_W-1:0] ptr_o
);
  logic last;
  assign step_o = access_i & ~busy_i & (nw_i != '0);
  assign last   = ({1'b0, ptr_o} == nw_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (clr_i)   ptr_o <= '0;
    else if (step_o)  ptr_o <= last ? '0 : ptr_o + PTR_W'(1);
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_o == '0) || ({1'b0, ptr_o} < nw_i)) else $error("ptr range"); // R4
  AST_CLR_ZEROES_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_o == '0)) else $error("ptr clr"); // R6
  AST_BUSY_HOLDS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clr_i) |=> $stable(ptr_o)) else $error("ptr moved busy"); // R7
  AST_NO_WORDS_PTR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nw_i == '0 && !clr_i && ptr_o == '0) |=> (ptr_o == '0)) else $error("ptr moved"); // R5
endmodule

// File: rtl/hsp_state_bank.sv
module hsp_state_bank #(
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 16,
  parameter int LEN_W     = 64,
  localparam int PTR_W    = $clog2(MAX_WORDS),
  localparam int STATE_W  = DATA_W * MAX_WORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [PTR_W-1:0]   wr_idx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               len_lo_we_i,
  input  logic               len_hi_we_i,
  input  logic               upd_i,
  input  logic [STATE_W-1:0] core_state_i,
  input  logic [LEN_W-1:0]   core_len_i,
  output logic [STATE_W-1:0] state_o,
  output logic [LEN_W-1:0]   len_o
);
  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q <= '0;
      else if (upd_i)                               word_q <= core_state_i[g*DATA_W +: DATA_W];
      else if (wr_en_i && wr_idx_i == PTR_W'(g))    word_q <= wdata_i;
    end
    assign state_o[g*DATA_W +: DATA_W] = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o <= '0;
    end else if (upd_i) begin
      len_o <= core_len_i;
    end else begin
      if (len_lo_we_i) len_o[DATA_W-1:0]     <= wdata_i;
      if (len_hi_we_i) len_o[LEN_W-1:DATA_W] <= wdata_i[LEN_W-DATA_W-1:0];
    end
  end

  AST_CORE_UPDATE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (state_o == $past(core_state_i)) && (len_o == $past(core_len_i)))
    else $error("core update lost"); // R12
endmodule

// File: rtl/hash_state_port.sv
module hash_state_port
  import hsp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 16,
  parameter int LEN_W     = 64,
  localparam int PTR_W    = $clog2(MAX_WORDS),
  localparam int CNT_W    = PTR_W + 1,
  localparam int STATE_W  = DATA_W * MAX_WORDS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic                reg_re_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                busy_i,
  input  logic                core_upd_i,
  input  logic [STATE_W-1:0]  core_state_i,
  input  logic [LEN_W-1:0]    core_len_i,
  output logic [STATE_W-1:0]  state_o,
  output logic [LEN_W-1:0]    len_o,
  output logic [ALGO_W-1:0]   algo_o,
  output logic                hmac_en_o,
  output logic [ENDIAN_W-1:0] endian_o,
  output logic                start_o
);
  logic sel_mode, sel_chain, sel_op, sel_status, sel_lo, sel_hi;
  logic ptr_clr, step, chain_acc;
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] nw;
  logic [DATA_W-1:0] rd_val, mode_rd, chain_rd;

  assign sel_mode   = reg_addr_i == ADDR_W'(OFS_MODE);
  assign sel_chain  = reg_addr_i == ADDR_W'(OFS_CHAIN);
  assign sel_op     = reg_addr_i == ADDR_W'(OFS_OP);
  assign sel_status = reg_addr_i == ADDR_W'(OFS_STATUS);
  assign sel_lo     = reg_addr_i == ADDR_W'(OFS_LEN_LO);
  assign sel_hi     = reg_addr_i == ADDR_W'(OFS_LEN_HI);

  assign nw        = CNT_W'(chain_words(algo_o));
  assign chain_acc = sel_chain & (reg_we_i | reg_re_i);

  hsp_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk_i, .rst_ni,
    .mode_we_i (reg_we_i & sel_mode),
    .op_we_i   (reg_we_i & sel_op),
    .wdata_i   (reg_wdata_i),
    .algo_o, .hmac_en_o, .endian_o, .start_o,
    .ptr_clr_o (ptr_clr)
  );

  hsp_word_ptr #(.MAX_WORDS(MAX_WORDS)) u_ptr (
    .clk_i, .rst_ni,
    .clr_i    (ptr_clr),
    .access_i (chain_acc),
    .busy_i,
    .nw_i     (nw),
    .step_o   (step),
    .ptr_o    (ptr)
  );

  hsp_state_bank #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i     (step & reg_we_i),
    .wr_idx_i    (ptr),
    .wdata_i     (reg_wdata_i),
    .len_lo_we_i (reg_we_i & sel_lo),
    .len_hi_we_i (reg_we_i & sel_hi),
    .upd_i       (core_upd_i),
    .core_state_i, .core_len_i,
    .state_o, .len_o
  );

  always_comb begin
    mode_rd = '0;
    mode_rd[ALGO_LSB +: ALGO_W]     = algo_o;
    mode_rd[HMAC_BIT]               = hmac_en_o;
    mode_rd[ENDIAN_LSB +: ENDIAN_W] = endian_o;
  end

  assign chain_rd = step ? state_o[ptr*DATA_W +: DATA_W] : '0;

  always_comb begin
    rd_val = '0;
    if (sel_mode)   rd_val = mode_rd;
    if (sel_chain)  rd_val = chain_rd;
    if (sel_status) rd_val = DATA_W'(busy_i);
    if (sel_lo)     rd_val = len_o[DATA_W-1:0];
    if (sel_hi)     rd_val = len_o[LEN_W-1:DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_re_i) reg_rdata_o <= rd_val;
  end

  AST_BUSY_CHAIN_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && sel_chain && busy_i) |=> (reg_rdata_o == '0)) else $error("busy read"); // R7
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && sel_status) |=> (reg_rdata_o[DATA_W-1:1] == '0)) else $error("status"); // R9
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> $stable(reg_rdata_o)) else $error("rdata moved"); // R2
  AST_BUSY_STATE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !core_upd_i) |=> $stable(state_o)) else $error("state moved busy"); // R7
endmodule

// File: tb/hash_state_port_test.sv
module hash_state_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = 0;
  logic we = 0, re = 0, busy = 0, upd = 0;
  logic [31:0] wdata = 0;
  logic [511:0] core_state = 0;
  logic [63:0] core_len = 0;
  logic [31:0] rdata;
  logic [511:0] state;
  logic [63:0] len;
  logic [2:0] algo;
  logic hmac;
  logic [5:0] endian;
  logic start;

  int checks = 0, fails = 0;
  logic [31:0] m_state [16];
  logic [63:0] m_len = 0;
  int m_ptr = 0;
  logic [2:0] m_algo = 0;
  logic m_hmac = 0;
  logic [5:0] m_endian = 0;
  logic [31:0] m_rdata = 0;
  logic m_start = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_state_port uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we), .reg_re_i(re),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_i(busy), .core_upd_i(upd),
    .core_state_i(core_state), .core_len_i(core_len), .state_o(state), .len_o(len),
    .algo_o(algo), .hmac_en_o(hmac), .endian_o(endian), .start_o(start)
  );

  function automatic int words_for(logic [2:0] a);
    if (a == 0 || a == 1 || a == 4) return 8;
    if (a == 2 || a == 3) return 16;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(int a);
    int n = words_for(m_algo);
    case (a)
      'h00: return {m_endian, 3'b0, m_hmac, 3'b0, m_algo, 16'b0};
      'h04: return (busy || n == 0) ? 32'h0 : m_state[m_ptr];
      'h58: return {31'b0, busy};
      'h60: return m_len[31:0];
      'h64: return m_len[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("rdata", 64'(rdata), 64'(m_rdata));
    chk("start", 64'(start), 64'(m_start));
    chk("mode", {hmac, endian, algo}, {m_hmac, m_endian, m_algo});
    chk("len", len, m_len);
    for (int i = 0; i < 16; i++) chk($sformatf("word%0d", i), 64'(state[i*32 +: 32]), 64'(m_state[i]));
  endtask

  task automatic model_update();
    int a = int'(addr);
    int n = words_for(m_algo);
    if (re) m_rdata = model_read(a);
    m_start = we && a == 'h08 && wdata[0];
    if (we && a == 'h00) begin
      m_algo = wdata[18:16]; m_hmac = wdata[22]; m_endian = wdata[31:26]; m_ptr = 0;
    end
    if (m_start) m_ptr = 0;
    if ((we || re) && a == 'h04 && !busy && n != 0) begin
      if (we) m_state[m_ptr] = wdata;
      m_ptr = (m_ptr + 1) % n;
    end
    if (we && a == 'h60) m_len[31:0] = wdata;
    if (we && a == 'h64) m_len[63:32] = wdata;
    if (upd) begin
      for (int i = 0; i < 16; i++) m_state[i] = core_state[i*32 +: 32];
      m_len = core_len;
    end
  endtask

  task automatic cyc(int a, logic w, logic r, logic [31:0] d);
    addr = 12'(a); we = w; re = r; wdata = d;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
    we = 0; re = 0; upd = 0;
  endtask

  task automatic wr(int a, logic [31:0] d); cyc(a, 1, 0, d); endtask
  task automatic rd(int a); cyc(a, 0, 1, 0); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_state[i] = 0;
    repeat (3) @(negedge clk);
    tag = "R1"; compare_all();
    rst_n = 1;
    @(negedge clk); compare_all();

    tag = "R10"; wr('h00, 32'hA840_0000 | (32'd0 << 16)); rd('h00);
    wr('h00, 32'hFFBF_FFFF); rd('h00);
    tag = "R3"; wr('h00, 32'h0000_0000);
    for (int i = 0; i < 8; i++) wr('h04, 32'h1000_0000 + i * 32'h111);
    tag = "R2"; for (int i = 0; i < 8; i++) rd('h04);
    tag = "R4"; rd('h04); rd('h04);
    wr('h00, 32'h0003_0000);
    for (int i = 0; i < 16; i++) wr('h04, 32'hC0DE_0000 ^ (i * 32'h01010101));
    for (int i = 0; i < 17; i++) rd('h04);
    wr('h00, 32'h0004_0000); for (int i = 0; i < 9; i++) rd('h04);
    wr('h00, 32'h0001_0000); for (int i = 0; i < 9; i++) rd('h04);
    wr('h00, 32'h0002_0000); for (int i = 0; i < 12; i++) rd('h04);
    tag = "R6"; wr('h00, 32'h0000_0000); rd('h04);
    rd('h04); rd('h04); wr('h08, 32'h1); rd('h04);
    rd('h04); wr('h08, 32'h0); rd('h04);
    tag = "R11"; wr('h08, 32'h3); rd('h08); rd('h1F0); cyc('h04, 1, 1, 32'h5555_AAAA); rd('h04);
    tag = "R7"; rd('h04); rd('h04);
    busy = 1; rd('h04); wr('h04, 32'hDEAD_BEEF); rd('h04); rd('h04);
    busy = 0; rd('h04); rd('h04);
    tag = "R9"; rd('h58); busy = 1; rd('h58); busy = 0; rd('h58);
    tag = "R5";
    for (int c = 5; c < 8; c++) begin
      wr('h00, 32'(c) << 16); rd('h04); wr('h04, 32'h7777_7777); rd('h04);
    end
    wr('h00, 32'h0000_0000); rd('h04); rd('h04);
    tag = "R8"; wr('h60, 32'h89AB_CDEF); wr('h64, 32'h0123_4567); rd('h60); rd('h64);
    busy = 1; wr('h60, 32'h1111_2222); rd('h60); busy = 0;
    tag = "R12";
    for (int i = 0; i < 16; i++) core_state[i*32 +: 32] = 32'hA5A5_0000 + 32'(i * 7);
    core_len = 64'hFEED_FACE_0BAD_F00D;
    upd = 1; busy = 1; cyc('h00, 0, 0, 0);
    busy = 0; wr('h00, 32'h0000_0000);
    core_state = ~core_state; core_len = ~core_len;
    upd = 1; cyc('h04, 1, 0, 32'h1234_5678);
    upd = 1; cyc('h60, 1, 0, 32'h0);
    for (int i = 0; i < 8; i++) rd('h04);
    rd('h64);
    cyc('h00, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule